// File: doc/BRIEF.md
# Always-On Wakeup Pin Monitor

This block watches a parameterised set of wakeup pins for a processor that is asleep, and raises one wake request when an enabled pin sees the activity it was configured for. Software sets the block up through a plain 32-bit register port. There are two storage-only timer words, followed by five banks of words: enable, falling-edge select, rising-edge select, level-high select, and event status. Each bank holds as many 32-bit words as are needed to cover the pin count.

Before the processor goes to sleep, software clears every status word and then raises `arm`. While `arm` is high, each pin is passed through a two-flop synchroniser. Every configured rising edge, falling edge or high level of a pin sets that pin's sticky status bit. The registered `wake` output goes high while any pin has both its status bit and its enable bit set. It stays high until software clears those status bits by writing zeros.

Top module: `wake_monitor`

## Requirements
- R1: The register at byte address (bank × S + word + 2) × 4 holds word `word` of bank `bank`, where S = ceil(PIN_COUNT/32). The banks are numbered enable 0, falling 1, rising 2, polarity 3, status 4. Byte addresses 0x00 and 0x04 are two read/write timer storage words. With the default of 40 pins these addresses are: enable 0x08/0x0C, falling 0x10/0x14, rising 0x18/0x1C, polarity 0x20/0x24, status 0x28/0x2C.
- R2: Pin p is controlled by bit p mod 32 of word p/32 in every bank.
- R3: After reset, every register reads zero and `wake` is low.
- R4: While armed, a low-to-high change of a synchronised pin with its rising bit set sets its status bit. A high-to-low change with only the rising bit set sets nothing.
- R5: While armed, a high-to-low change with the falling bit set sets the status bit. With both edge bits set, either edge sets it.
- R6: While armed, a pin with its polarity bit set keeps setting its status bit for as long as it is high, including right after software clears that bit.
- R7: While `arm` is low, pin activity leaves the status bits unchanged.
- R8: Status bits are sticky. A write replaces the status word with the written value, so a written zero clears a bit.
- R9: `wake` is a register that equals, one cycle later, the OR over all bits of (status AND enable). A set status bit whose enable bit is clear does not wake.
- R10: Reads of word addresses at or beyond 2 + 5·S return zero, and writes to them change nothing.
- R11: Bits of any bank that lie at or above PIN_COUNT always read zero.
- R12: A write to one word leaves every other word unchanged, so a read-modify-write of a single enable bit keeps the other bits of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | High while the monitor records events |
| pins | input | PIN_COUNT | Asynchronous wakeup pins |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address (word aligned) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| wake | output | 1 | Registered wake request |

## Verification
Each detection mode is tried with pulses on pins in both status words. The rising test also drops the pin, which shows that a rising-only setting ignores falls. The both-edges test separates the two edges by clearing status in between. The level test clears status while the pin is still high, which shows that level detection differs from edge detection. Pin toggles with `arm` low, and status bits set with enable clear, show that arming and enable each gate a different stage of the path.

// File: rtl/wake_monitor.sv
module wake_monitor #(
  parameter int PIN_COUNT = 40,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic [PIN_COUNT-1:0] pins,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 wake
);
  localparam int STRIDE = (PIN_COUNT + 31) / 32;
  localparam int PADW   = STRIDE * 32;
  localparam int NBANK  = 5;
  localparam int NWORDS = 2 + NBANK * STRIDE;
  localparam int B_EN = 0, B_FALL = 1, B_RISE = 2, B_POL = 3, B_STAT = 4;
  localparam logic [PADW-1:0] VMASK = PADW'({PIN_COUNT{1'b1}});

  logic [31:0] widx;
  logic [31:0] timer_q [2];
  logic [31:0] bank_q  [NBANK][STRIDE];
  logic [31:0] stat_d  [STRIDE];
  logic [PIN_COUNT-1:0] sync1_q, sync2_q, prev_q;
  logic [PADW-1:0] en_v, fall_v, rise_v, pol_v, stat_v, hit_v, pend;

  assign widx = 32'(addr[ADDR_W-1:2]);

  for (genvar w = 0; w < STRIDE; w++) begin : g_flat
    assign en_v  [w*32 +: 32] = bank_q[B_EN][w];
    assign fall_v[w*32 +: 32] = bank_q[B_FALL][w];
    assign rise_v[w*32 +: 32] = bank_q[B_RISE][w];
    assign pol_v [w*32 +: 32] = bank_q[B_POL][w];
    assign stat_v[w*32 +: 32] = bank_q[B_STAT][w];
  end

  assign hit_v = PADW'(( sync2_q & ~prev_q & rise_v[PIN_COUNT-1:0])
                     | (~sync2_q &  prev_q & fall_v[PIN_COUNT-1:0])
                     | ( sync2_q &  pol_v[PIN_COUNT-1:0]));

  assign pend = stat_v & en_v;

  always_comb begin
    for (int w = 0; w < STRIDE; w++) begin
      stat_d[w] = bank_q[B_STAT][w];
      if (wr_en && widx == 32'(2 + B_STAT*STRIDE + w))
        stat_d[w] = wdata & VMASK[w*32 +: 32];
      if (arm)
        stat_d[w] = stat_d[w] | hit_v[w*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      wake    <= 1'b0;
      for (int i = 0; i < 2; i++) timer_q[i] <= '0;
      for (int r = 0; r < NBANK; r++)
        for (int w = 0; w < STRIDE; w++) bank_q[r][w] <= '0;
    end else begin
      sync1_q <= pins;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      wake    <= |pend;
      for (int i = 0; i < 2; i++)
        if (wr_en && widx == 32'(i)) timer_q[i] <= wdata;
      for (int r = 0; r < B_STAT; r++)
        for (int w = 0; w < STRIDE; w++)
          if (wr_en && widx == 32'(2 + r*STRIDE + w))
            bank_q[r][w] <= wdata & VMASK[w*32 +: 32];
      for (int w = 0; w < STRIDE; w++) bank_q[B_STAT][w] <= stat_d[w];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < 2; i++)
      if (widx == 32'(i)) rdata = timer_q[i];
    for (int r = 0; r < NBANK; r++)
      for (int w = 0; w < STRIDE; w++)
        if (widx == 32'(2 + r*STRIDE + w)) rdata = bank_q[r][w];
  end
endmodule

// File: rtl/wake_monitor_checker.sv
module wake_monitor_checker #(
  parameter int PADW   = 64,
  parameter int NWORDS = 12,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic [PADW-1:0]   stat_v,
  input logic [PADW-1:0]   pend,
  input logic              wake
);
  logic [31:0] word_addr;
  assign word_addr = 32'(addr) >> 2;

  assert_wake_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |=> wake);
  assert_wake_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend) |=> !wake);
  assert_wake_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake) |-> $past(|stat_v));
  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((stat_v & $past(stat_v)) == $past(stat_v)));
  assert_disarm_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !wr_en) |=> $stable(stat_v));
  assert_range_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (word_addr >= 32'(NWORDS)) |-> (rdata == 32'd0));
endmodule

bind wake_monitor wake_monitor_checker #(
  .PADW(PADW), .NWORDS(NWORDS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .wr_en(wr_en), .addr(addr),
  .rdata(rdata), .stat_v(stat_v), .pend(pend), .wake(wake)
);

// File: tb/wake_monitor_bench.sv
module wake_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 40;

  logic clk = 0, rst_n = 0, arm = 0, wr_en = 0, wake;
  logic [NP-1:0] pins = '0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, fails = 0, cycles = 0;

  wake_monitor #(.PIN_COUNT(NP), .ADDR_W(8)) u_wake_monitor (
    .clk(clk), .rst_n(rst_n), .arm(arm), .pins(pins), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wake(wake));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic clean();
    arm = 0;
    pins = '0;
    for (int a = 8'h08; a <= 8'h2C; a += 4) wr(8'(a), 32'd0);
    cyc(4);
    wr(8'h28, 0); wr(8'h2C, 0);
    cyc(2);
  endtask

  task automatic t_reset();
    for (int a = 0; a <= 8'h2C; a += 4) rdchk("R3 reset reg", 8'(a), 32'd0);
    chk("R3 reset wake", 32'(wake), 32'd0);
  endtask

  task automatic t_map();
    wr(8'h00, 32'h1234_5678); wr(8'h04, 32'h9ABC_DEF0);
    for (int r = 0; r < 4; r++)
      for (int w = 0; w < 2; w++)
        wr(8'((r*2 + w + 2)*4), 32'h0000_0011 * (r*2 + w + 1));
    rdchk("R1 timer0", 8'h00, 32'h1234_5678);
    rdchk("R1 timer1", 8'h04, 32'h9ABC_DEF0);
    for (int r = 0; r < 4; r++)
      for (int w = 0; w < 2; w++)
        rdchk("R1 bank word", 8'((r*2 + w + 2)*4), 32'h0000_0011 * (r*2 + w + 1));
    clean();
    // status at 0x28 bit7 with enable at 0x08 bit7 gives wake
    wr(8'h08, 32'h80); wr(8'h28, 32'h80);
    cyc(1);
    chk("R1 status/enable location wake", 32'(wake), 1);
    clean();
  endtask

  task automatic t_rise();
    wr(8'h18, 32'h8); wr(8'h1C, 32'h8);
    wr(8'h08, 32'h8); wr(8'h0C, 32'h8);
    arm = 1;
    pins[3] = 1;
    cyc(5);
    rdchk("R4 rise status w0", 8'h28, 32'h8);
    rdchk("R2 pin3 not in w1", 8'h2C, 32'h0);
    chk("R4 rise wake", 32'(wake), 1);
    wr(8'h28, 0);
    pins[3] = 0;
    cyc(5);
    rdchk("R4 fall ignored", 8'h28, 32'h0);
    chk("R9 wake dropped", 32'(wake), 0);
    pins[35] = 1;
    cyc(5);
    rdchk("R2 pin35 in w1 bit3", 8'h2C, 32'h8);
    rdchk("R2 pin35 not in w0", 8'h28, 32'h0);
    clean();
  endtask

  task automatic t_fall();
    wr(8'h14, 32'h8); wr(8'h0C, 32'h8);
    arm = 1;
    pins[35] = 1;
    cyc(5);
    rdchk("R5 rise ignored by falling", 8'h2C, 32'h0);
    pins[35] = 0;
    cyc(5);
    rdchk("R5 fall status", 8'h2C, 32'h8);
    chk("R5 fall wake", 32'(wake), 1);
    clean();
  endtask

  task automatic t_both();
    wr(8'h10, 32'h400); wr(8'h18, 32'h400); wr(8'h08, 32'h400);
    arm = 1;
    pins[10] = 1;
    cyc(5);
    rdchk("R5 both rise", 8'h28, 32'h400);
    wr(8'h28, 0);
    cyc(2);
    rdchk("R5 both cleared", 8'h28, 32'h0);
    pins[10] = 0;
    cyc(5);
    rdchk("R5 both fall", 8'h28, 32'h400);
    clean();
  endtask

  task automatic t_level();
    wr(8'h20, 32'h0010_0000); wr(8'h08, 32'h0010_0000);
    arm = 1;
    pins[20] = 1;
    cyc(5);
    rdchk("R6 level set", 8'h28, 32'h0010_0000);
    wr(8'h28, 0);
    cyc(2);
    rdchk("R6 level re-set while high", 8'h28, 32'h0010_0000);
    chk("R6 level wake", 32'(wake), 1);
    pins[20] = 0;
    cyc(5);
    wr(8'h28, 0);
    cyc(3);
    rdchk("R6 level low stays clear", 8'h28, 32'h0);
    chk("R6 wake low", 32'(wake), 0);
    clean();
  endtask

  task automatic t_disarm();
    wr(8'h18, 32'h20); wr(8'h10, 32'h20); wr(8'h20, 32'h20); wr(8'h08, 32'h20);
    arm = 0;
    pins[5] = 1; cyc(5);
    pins[5] = 0; cyc(5);
    pins[5] = 1; cyc(5);
    rdchk("R7 disarmed no status", 8'h28, 32'h0);
    chk("R7 disarmed no wake", 32'(wake), 0);
    clean();
  endtask

  task automatic t_sticky_gate();
    wr(8'h18, 32'h2);
    arm = 1;
    pins[1] = 1; cyc(5);
    pins[1] = 0; cyc(5);
    rdchk("R8 sticky after pulse", 8'h28, 32'h2);
    chk("R9 no wake without enable", 32'(wake), 0);
    wr(8'h08, 32'h2);
    cyc(1);
    chk("R9 wake after enable", 32'(wake), 1);
    wr(8'h28, 32'h0);
    rdchk("R8 cleared by zero write", 8'h28, 32'h0);
    cyc(1);
    chk("R9 wake low after clear", 32'(wake), 0);
    clean();
  endtask

  task automatic t_range();
    wr(8'h00, 32'hCAFE_0001);
    wr(8'h30, 32'hDEAD_BEEF); wr(8'h3C, 32'hDEAD_BEEF); wr(8'hFC, 32'hFFFF_FFFF);
    rdchk("R10 read 0x30", 8'h30, 32'h0);
    rdchk("R10 read 0xFC", 8'hFC, 32'h0);
    rdchk("R10 timer0 untouched", 8'h00, 32'hCAFE_0001);
    for (int a = 8'h08; a <= 8'h2C; a += 4) rdchk("R10 banks untouched", 8'(a), 32'h0);
  endtask

  task automatic t_pad();
    wr(8'h0C, 32'hFFFF_FFFF);
    rdchk("R11 enable w1 masked", 8'h0C, 32'h0000_00FF);
    wr(8'h2C, 32'hFFFF_FF00);
    rdchk("R11 status w1 masked", 8'h2C, 32'h0);
    wr(8'h08, 32'hFFFF_FFFF);
    rdchk("R11 word0 full", 8'h08, 32'hFFFF_FFFF);
    clean();
  endtask

  task automatic t_rmw();
    logic [31:0] d;
    wr(8'h08, 32'hA5A5_0000);
    wr(8'h0C, 32'h0000_0042);
    rd(8'h08, d);
    wr(8'h08, d | 32'h2);
    rdchk("R12 rmw set keeps others", 8'h08, 32'hA5A5_0002);
    rd(8'h08, d);
    wr(8'h08, d & ~32'h0001_0000);
    rdchk("R12 rmw clear keeps others", 8'h08, 32'hA5A4_0002);
    rdchk("R12 neighbour word kept", 8'h0C, 32'h0000_0042);
    clean();
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    t_reset();
    t_map();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_disarm();
    t_sticky_gate();
    t_range();
    t_pad();
    t_rmw();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule